// File: doc/BRIEF.md
# Word Arithmetic and Flag Unit

This block does the accumulator-pair arithmetic of a small 8-bit processor core. Each operation is selected by a 3-bit code. It can add a 16-bit immediate to the accumulator pair, subtract the immediate from it, or compare the two. It can also step an 8-bit register up or down, or step a 16-bit register pair up or down. The core's decoder supplies the operands and the current zero (Z), auxiliary-carry (AC) and carry (CY) flags, then pulses `go` for one cycle.

One clock later the block presents the result and a write strobe for that result. It also presents the flag values the core should adopt and the number of processor clocks the operation accounts for. Each operation class follows its own policy for which flags it touches. A flag that an operation leaves alone is passed through from its input unchanged.

Top module: `word_alu`

## Requirements
- R1: Outputs are registered. On the clock edge where `go` is high, the block captures the operation, and `done` is high for exactly the following cycle. While `go` stays low, `result`, `wr_en`, the flags and `clocks` hold their values. Reset clears every output to zero.
- R2: Op code 0 (word add) gives `result` = (acc + imm) mod 2^16 with `wr_en` = 1. `cy_out` is the carry out of bit 15.
- R3: Op code 1 (word subtract) gives `result` = (acc - imm) mod 2^16 with `wr_en` = 1. `cy_out` is 1 exactly when acc < imm, taking both as unsigned.
- R4: Op code 2 (word compare) drives the difference onto `result` and sets flags as in R3, but `wr_en` = 0.
- R5: `z_out` is 1 exactly when the result is zero over its full width: 16 bits for codes 0-2, and 8 bits for codes 3-4.
- R6: For codes 0-2, `ac_out` is the carry out of bit 3 (add), or the borrow out of bit 3 (subtract and compare).
- R7: Op code 3 (byte increment) and code 4 (byte decrement) place reg8 ± 1 (mod 256) in `result[7:0]` and zero in `result[15:8]`, with `wr_en` = 1. `ac_out` is the carry or borrow out of bit 3, and `cy_out` equals `cy_in`.
- R8: Op code 5 (pair increment) and code 6 (pair decrement) give pair ± 1 mod 2^16, so 0xFFFF steps up to 0x0000 and 0x0000 steps down to 0xFFFF, with `wr_en` = 1. All three flags equal their inputs.
- R9: `clocks` reports 6 for codes 0-2, 2 for codes 3-4 and 4 for codes 5-6. Op code 7 is reserved. It gives `result` = 0, `wr_en` = 0, `clocks` = 0 and passes the flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start one operation this cycle |
| op | input | 3 | Operation code |
| acc | input | 16 | Accumulator pair |
| imm | input | 16 | Immediate word |
| reg8 | input | 8 | Byte register operand |
| pair | input | 16 | Register-pair operand |
| z_in | input | 1 | Current zero flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| cy_in | input | 1 | Current carry flag |
| done | output | 1 | Outputs valid for the last operation |
| result | output | 16 | Result value |
| wr_en | output | 1 | Result should be written back |
| z_out | output | 1 | Next zero flag |
| ac_out | output | 1 | Next auxiliary-carry flag |
| cy_out | output | 1 | Next carry flag |
| clocks | output | 4 | Clock count of the operation |

## Verification
The bench looks for off-by-one errors at the edges of the wraps. It adds 0xFFFF + 1, increments the byte 0xFF, and steps the pair across 0xFFFF and 0x0000. A design that kept the wrong width for Z, or let the carry leak into a byte or pair operation, would report the wrong flags on these vectors. It also subtracts a larger value from a smaller one, with nibbles chosen so that bit 3 does or does not borrow. A swapped borrow sense or a wrong AC bit position shows up there. Further vectors check that a compare never raises `wr_en`, and that an increment of a byte or pair keeps a set incoming CY, catching a design that clears CY.

// File: rtl/word_alu.sv
module word_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [2:0]  op,
  input  logic [15:0] acc,
  input  logic [15:0] imm,
  input  logic [7:0]  reg8,
  input  logic [15:0] pair,
  input  logic        z_in,
  input  logic        ac_in,
  input  logic        cy_in,
  output logic        done,
  output logic [15:0] result,
  output logic        wr_en,
  output logic        z_out,
  output logic        ac_out,
  output logic        cy_out,
  output logic [3:0]  clocks
);

  logic [16:0] sum, dif;
  logic [4:0]  nib_add, nib_sub;
  logic [15:0] n_res;
  logic        n_wr, n_z, n_ac, n_cy;
  logic [3:0]  n_clk;

  assign sum     = {1'b0, acc} + {1'b0, imm};
  assign dif     = {1'b0, acc} - {1'b0, imm};
  assign nib_add = {1'b0, acc[3:0]} + {1'b0, imm[3:0]};
  assign nib_sub = {1'b0, acc[3:0]} - {1'b0, imm[3:0]};

  always_comb begin
    n_res = '0;
    n_wr  = 1'b0;
    n_z   = z_in;
    n_ac  = ac_in;
    n_cy  = cy_in;
    n_clk = 4'd0;
    case (op)
      3'd0: begin
        n_res = sum[15:0]; n_wr = 1'b1;
        n_z = (sum[15:0] == 16'h0); n_ac = nib_add[4]; n_cy = sum[16];
        n_clk = 4'd6;
      end
      3'd1, 3'd2: begin
        n_res = dif[15:0]; n_wr = (op == 3'd1);
        n_z = (dif[15:0] == 16'h0); n_ac = nib_sub[4]; n_cy = dif[16];
        n_clk = 4'd6;
      end
      3'd3: begin
        n_res = {8'h00, reg8 + 8'd1}; n_wr = 1'b1;
        n_z = (reg8 == 8'hFF); n_ac = (reg8[3:0] == 4'hF);
        n_clk = 4'd2;
      end
      3'd4: begin
        n_res = {8'h00, reg8 - 8'd1}; n_wr = 1'b1;
        n_z = (reg8 == 8'h01); n_ac = (reg8[3:0] == 4'h0);
        n_clk = 4'd2;
      end
      3'd5: begin n_res = pair + 16'd1; n_wr = 1'b1; n_clk = 4'd4; end
      3'd6: begin n_res = pair - 16'd1; n_wr = 1'b1; n_clk = 4'd4; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      result <= '0;
      wr_en <= 1'b0;
      z_out <= 1'b0;
      ac_out <= 1'b0;
      cy_out <= 1'b0;
      clocks <= '0;
    end else begin
      done <= go;
      if (go) begin
        result <= n_res;
        wr_en  <= n_wr;
        z_out  <= n_z;
        ac_out <= n_ac;
        cy_out <= n_cy;
        clocks <= n_clk;
      end
    end
  end

  a_r1_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(go));
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(result) && $stable(wr_en) && $stable(clocks));
  a_r3_sub_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 3'd1 |=> result + $past(imm) == $past(acc));
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 3'd2 |=> !wr_en);
  a_r7_byte_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
    go && (op == 3'd3 || op == 3'd4) |=> cy_out == $past(cy_in) && result[15:8] == 8'h00);
  a_r8_pair_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    go && (op == 3'd5 || op == 3'd6) |=>
      z_out == $past(z_in) && ac_out == $past(ac_in) && cy_out == $past(cy_in));
  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 3'd7 |=> !wr_en && clocks == 4'd0);

endmodule

// File: tb/tb_word_alu.sv
module tb_word_alu;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] acc = '0, imm = '0, pair = '0;
  logic [7:0] reg8 = '0;
  logic z_in = 1'b0, ac_in = 1'b0, cy_in = 1'b0;
  logic done, wr_en, z_out, ac_out, cy_out;
  logic [15:0] result;
  logic [3:0] clocks;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  word_alu dut (.clk(clk), .rst_n(rst_n), .go(go), .op(op), .acc(acc), .imm(imm),
    .reg8(reg8), .pair(pair), .z_in(z_in), .ac_in(ac_in), .cy_in(cy_in),
    .done(done), .result(result), .wr_en(wr_en), .z_out(z_out),
    .ac_out(ac_out), .cy_out(cy_out), .clocks(clocks));

  task automatic check(string req, logic [24:0] got, logic [24:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got done/res/wr/z/ac/cy/clk=%h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [24:0] pack(logic d, logic [15:0] r, logic w, logic z,
                                       logic a, logic c, logic [3:0] k);
    return {d, r, w, z, a, c, k};
  endfunction

  task automatic run(string req, logic [2:0] o, logic [15:0] a, logic [15:0] i,
                     logic [7:0] r8, logic [15:0] p, logic zi, logic ai, logic ci,
                     logic [15:0] er, logic ew, logic ez, logic ea, logic ec, logic [3:0] ek);
    @(negedge clk);
    op = o; acc = a; imm = i; reg8 = r8; pair = p;
    z_in = zi; ac_in = ai; cy_in = ci; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(req, pack(done, result, wr_en, z_out, ac_out, cy_out, clocks),
          pack(1'b1, er, ew, ez, ea, ec, ek));
  endtask

  task automatic t_reset;
    check("R1 reset", pack(done, result, wr_en, z_out, ac_out, cy_out, clocks), '0);
  endtask

  task automatic t_add;
    run("R2 R6 add nibble carry", 3'd0, 16'h1234, 16'h0FCD, 8'h00, 16'h0, 0, 0, 0, 16'h2201, 1, 0, 1, 0, 4'd6);
    run("R2 R5 add wrap to zero", 3'd0, 16'hFFFF, 16'h0001, 8'h00, 16'h0, 0, 0, 0, 16'h0000, 1, 1, 1, 1, 4'd6);
    run("R2 add plain", 3'd0, 16'h1000, 16'h2000, 8'h00, 16'h0, 1, 1, 1, 16'h3000, 1, 0, 0, 0, 4'd6);
  endtask

  task automatic t_sub;
    run("R3 R6 sub nibble borrow", 3'd1, 16'h5000, 16'h0001, 8'h00, 16'h0, 0, 0, 1, 16'h4FFF, 1, 0, 1, 0, 4'd6);
    run("R3 sub underflow", 3'd1, 16'h0003, 16'h0005, 8'h00, 16'h0, 0, 0, 0, 16'hFFFE, 1, 0, 1, 1, 4'd6);
    run("R3 R5 sub to zero", 3'd1, 16'h4242, 16'h4242, 8'h00, 16'h0, 0, 1, 1, 16'h0000, 1, 1, 0, 0, 4'd6);
  endtask

  task automatic t_cmp;
    run("R4 cmp less", 3'd2, 16'h0010, 16'h0020, 8'h00, 16'h0, 1, 1, 0, 16'hFFF0, 0, 0, 0, 1, 4'd6);
    run("R4 R5 cmp equal", 3'd2, 16'hABCD, 16'hABCD, 8'h00, 16'h0, 0, 0, 1, 16'h0000, 0, 1, 0, 0, 4'd6);
  endtask

  task automatic t_byte;
    run("R7 R5 inc8 wrap", 3'd3, 16'h0, 16'h0, 8'hFF, 16'h0, 0, 0, 1, 16'h0000, 1, 1, 1, 1, 4'd2);
    run("R7 inc8 plain", 3'd3, 16'h0, 16'h0, 8'h3E, 16'h0, 1, 1, 0, 16'h003F, 1, 0, 0, 0, 4'd2);
    run("R7 dec8 nibble borrow", 3'd4, 16'h0, 16'h0, 8'h10, 16'h0, 1, 0, 1, 16'h000F, 1, 0, 1, 1, 4'd2);
    run("R7 R5 dec8 to zero", 3'd4, 16'h0, 16'h0, 8'h01, 16'h0, 0, 1, 0, 16'h0000, 1, 1, 0, 0, 4'd2);
  endtask

  task automatic t_pair;
    run("R8 incp wrap", 3'd5, 16'h0, 16'h0, 8'h00, 16'hFFFF, 0, 1, 0, 16'h0000, 1, 0, 1, 0, 4'd4);
    run("R8 decp wrap", 3'd6, 16'h0, 16'h0, 8'h00, 16'h0000, 1, 0, 1, 16'hFFFF, 1, 1, 0, 1, 4'd4);
    run("R8 incp carry across byte", 3'd5, 16'h0, 16'h0, 8'h00, 16'h00FF, 0, 0, 1, 16'h0100, 1, 0, 0, 1, 4'd4);
  endtask

  task automatic t_reserved;
    run("R9 reserved op", 3'd7, 16'hFFFF, 16'h0001, 8'hFF, 16'h1234, 1, 1, 1, 16'h0000, 0, 1, 1, 1, 4'd0);
  endtask

  task automatic t_hold;
    run("R1 load", 3'd0, 16'h0100, 16'h0023, 8'h00, 16'h0, 0, 0, 0, 16'h0123, 1, 0, 0, 0, 4'd6);
    op = 3'd1; acc = 16'h0; imm = 16'h5;
    @(negedge clk);
    @(negedge clk);
    check("R1 hold while idle", pack(done, result, wr_en, z_out, ac_out, cy_out, clocks),
          pack(1'b0, 16'h0123, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6));
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_byte();
    t_pair();
    t_reserved();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule